// File: doc/BRIEF.md
# Sixteen-Times Oversampled Serial Character Receiver

This block turns an asynchronous serial line into characters. A programmable divisor sets the width of one sample tick, and sixteen ticks make one bit, so the bit rate is the clock frequency divided by sixteen times the divisor. After a valid start bit the receiver takes 5 to 8 data bits least significant first, an optional parity bit and one stop bit. Each bit is sampled at its centre.

Each finished character goes into a single holding register and raises a data-ready flag. Status flags are also kept for parity errors, framing errors, overruns and breaks. A data read strobe drops data-ready and a status read strobe clears the error flags. If a new character arrives before the held one has been read, the new one replaces it and the overrun flag is raised. After a framing error or a break, the receiver waits for the line to go high and then low again before it starts on the next character.

Top module: `serial_rx16`

## Requirements
- R1: One bit lasts 16 ticks, and one tick lasts `divisor` clock cycles. Characters are received correctly at different divisor values. While `divisor` is 0, no ticks occur and no character is produced.
- R2: A falling edge starts a character only if the line is still low at the eighth tick. A low pulse shorter than that produces no character, and the receiver goes back to idle.
- R3: Data bits are taken LSB first. The word length is set by `line_ctl[1:0]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_byte` above the word length read 0.
- R4: `line_ctl[3]` = 1 enables parity, and `line_ctl[4]` selects even parity when 1 and odd parity when 0. A wrong parity bit sets `err_parity`. When parity is disabled, no parity bit is expected and `line_ctl[4]` has no effect.
- R5: Only the first stop bit is checked. `line_ctl[2]`, the stop-count setting, has no effect on reception, so a new start bit may follow the first stop bit directly.
- R6: A stop bit sampled as 0 sets `err_frame` for that character. The receiver then restarts only on the next high-to-low transition of the line.
- R7: If the line is low for the whole character, through the stop bit, the receiver sets `err_break` and `err_frame` and loads 0 into `rx_byte`.
- R8: A finished character loads `rx_byte` and sets `data_ready`. A `rd_data` pulse clears `data_ready` on the next cycle.
- R9: If a character finishes while `data_ready` is set and no read is pending, the new byte replaces the old one and `err_overrun` is set.
- R10: The error flags are held until a `rd_status` pulse, which clears all four on the next cycle.
- R11: After reset, `data_ready`, `rx_byte` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd_in | input | 1 | Serial line, idle high |
| divisor | input | DIV_W | Clock cycles per sample tick; 0 stops the receiver |
| line_ctl | input | 5 | [1:0] word length, [2] stop count (ignored), [3] parity enable, [4] even parity |
| rd_data | input | 1 | Data read strobe |
| rd_status | input | 1 | Status read strobe |
| data_ready | output | 1 | An unread character is held |
| rx_byte | output | 8 | Held character |
| err_parity | output | 1 | Parity error seen |
| err_frame | output | 1 | Stop bit was 0 |
| err_overrun | output | 1 | An unread character was overwritten |
| err_break | output | 1 | Line stayed low for a whole character |

## Verification
Overrun is the hardest case to create from the ports. The scoreboard normally reads every character as soon as it arrives, so the bench switches that automatic read off, sends two characters, and only then lets the reader pop an expected entry that already carries the overrun flag. Break and resynchronisation need the line held low past a full character and then a clean character straight after. The glitch case needs a low pulse shorter than half a bit, followed by a real character that must be the only one to come out.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   localparam int LC_W   = 5;
   localparam int MAX_WL = 8;
   localparam int MIN_WL = 5;
   localparam int OSR    = 16;
   localparam int TCNT_W = $clog2(OSR);
   localparam int BIDX_W = $clog2(MAX_WL);

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic parity;
      logic frame;
      logic brk;
   } rx_err_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] sr;

   if (STAGES < 2) begin : g_bad_stages
      $error("serial_rx_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= 1'b1;
            else        sr[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[g] <= 1'b1;
            else        sr[g] <= sr[g-1];
         end
      end
   end

   assign dout = sr[STAGES-1];
endmodule

// File: rtl/serial_rx_tick.sv
module serial_rx_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   if (DIV_W < 2 || DIV_W > 32) begin : g_bad_width
      $error("serial_rx_tick: DIV_W must lie in 2..32");
   end

   assign wrap = (divisor != '0) && (cnt_q >= divisor - 1'b1);
   assign tick = wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (divisor == '0 || wrap)  cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
   end

   // R1: with a divisor above one, ticks never come on consecutive cycles
   assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor > 1) |=> (!tick || !$stable(divisor)));
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic [1:0]        wl_sel,
   input  logic              par_en,
   input  logic              par_even,
   output logic              done_o,
   output logic [MAX_WL-1:0] data_o,
   output rx_err_t           err_o
);
   rx_state_t         state;
   logic [TCNT_W-1:0] tcnt;
   logic [BIDX_W-1:0] bidx;
   logic [BIDX_W-1:0] last_idx;
   logic [MAX_WL-1:0] shreg;
   logic [1:0]        wl_q;
   logic              pen_q, peven_q, pbit_q, zero_q, prev_q;
   logic              mid_start, bit_end;

   localparam logic [TCNT_W-1:0] HALF_T = TCNT_W'(OSR/2 - 1);
   localparam logic [TCNT_W-1:0] FULL_T = TCNT_W'(OSR - 1);

   assign last_idx  = BIDX_W'(MIN_WL - 1) + BIDX_W'(wl_q);
   assign mid_start = tick && (tcnt == HALF_T);
   assign bit_end   = tick && (tcnt == FULL_T);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         tcnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         wl_q    <= '0;
         pen_q   <= 1'b0;
         peven_q <= 1'b0;
         pbit_q  <= 1'b0;
         zero_q  <= 1'b0;
         prev_q  <= 1'b0;
         done_o  <= 1'b0;
         data_o  <= '0;
         err_o   <= '0;
      end else begin
         done_o <= 1'b0;
         if (tick) prev_q <= line;
         if (tick && state != RX_IDLE) tcnt <= tcnt + 1'b1;
         case (state)
            RX_IDLE: begin
               if (tick && prev_q && !line) begin
                  state   <= RX_START;
                  tcnt    <= '0;
                  wl_q    <= wl_sel;
                  pen_q   <= par_en;
                  peven_q <= par_even;
               end
            end
            RX_START: begin
               if (mid_start) begin
                  tcnt <= '0;
                  if (!line) begin
                     state  <= RX_DATA;
                     bidx   <= '0;
                     shreg  <= '0;
                     zero_q <= 1'b1;
                  end else begin
                     state <= RX_IDLE;
                  end
               end
            end
            RX_DATA: begin
               if (bit_end) begin
                  shreg[bidx] <= line;
                  zero_q      <= zero_q & ~line;
                  if (bidx == last_idx) state <= pen_q ? RX_PAR : RX_STOP;
                  else                  bidx  <= bidx + 1'b1;
               end
            end
            RX_PAR: begin
               if (bit_end) begin
                  pbit_q <= line;
                  zero_q <= zero_q & ~line;
                  state  <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (bit_end) begin
                  done_o       <= 1'b1;
                  data_o       <= shreg;
                  err_o.frame  <= ~line;
                  err_o.brk    <= zero_q & ~line;
                  err_o.parity <= pen_q & ((^shreg) ^ pbit_q ^ ~peven_q);
                  state        <= RX_IDLE;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   // R2: data reception begins only after a low sample at mid start bit
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_DATA && $past(state) == RX_START) |-> !$past(line));

   // R7: a break character always carries a framing error
   assert_break_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o.brk) |-> err_o.frame);
endmodule

// File: rtl/serial_rx16.sv
module serial_rx16
   import serial_rx_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxd_in,
   input  logic [DIV_W-1:0]  divisor,
   input  logic [LC_W-1:0]   line_ctl,
   input  logic              rd_data,
   input  logic              rd_status,
   output logic              data_ready,
   output logic [MAX_WL-1:0] rx_byte,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun,
   output logic              err_break
);
   logic              line_s, tick, f_done;
   logic [MAX_WL-1:0] f_data;
   rx_err_t           f_err;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(rxd_in), .dout(line_s));

   serial_rx_tick #(.DIV_W(DIV_W)) tick_i (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick));

   serial_rx_frame frame_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
      .wl_sel(line_ctl[1:0]), .par_en(line_ctl[3]), .par_even(line_ctl[4]),
      .done_o(f_done), .data_o(f_data), .err_o(f_err));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_ready  <= 1'b0;
         rx_byte     <= '0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
         err_break   <= 1'b0;
      end else if (f_done) begin
         rx_byte     <= f_data;
         data_ready  <= 1'b1;
         err_parity  <= err_parity | f_err.parity;
         err_frame   <= err_frame  | f_err.frame;
         err_break   <= err_break  | f_err.brk;
         err_overrun <= err_overrun | (data_ready & ~rd_data);
      end else begin
         if (rd_data) data_ready <= 1'b0;
         if (rd_status) begin
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            err_break   <= 1'b0;
         end
      end
   end

   // R1: a stopped divisor yields no character
   assert_halt_zero_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0 && $past(divisor == '0)) |-> !f_done);

   // R5: the configuration word, stop count included, is always driven
   assert_cfg_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(line_ctl));

   // R8: a data read with no new character drops data_ready
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !f_done) |=> !data_ready);

   // R9: overwriting an unread character raises overrun
   assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (f_done && data_ready && !rd_data) |=> err_overrun);

   // R10: a status read with no new character clears all flags
   assert_status_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !f_done) |=> !(err_parity || err_frame || err_overrun || err_break));
endmodule

// File: tb/serial_rx16_tb_top.sv
module serial_rx16_tb_top;
   typedef struct packed {
      logic [7:0] d;
      logic       p;
      logic       f;
      logic       o;
      logic       b;
   } exp_t;

   logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
   logic [15:0] div = 16'd2;
   logic [4:0] lc = 5'b00011;
   logic       rd_data = 1'b0, rd_status = 1'b0;
   logic       data_ready, err_parity, err_frame, err_overrun, err_break;
   logic [7:0] rx_byte;

   exp_t q[$];
   int   checks = 0, fails = 0;
   int   bt = 32;
   bit   auto_rd = 1'b1;

   serial_rx16 dut_i (
      .clk(clk), .rst_n(rst_n), .rxd_in(rxd), .divisor(div), .line_ctl(lc),
      .rd_data(rd_data), .rd_status(rd_status), .data_ready(data_ready),
      .rx_byte(rx_byte), .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun), .err_break(err_break));

   always #4 clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [4:0] cfg(input int wl, input bit pen, input bit peven, input bit stop2);
      return {peven, pen, stop2, 2'(wl - 5)};
   endfunction

   task automatic line_bits(input bit v, input int n);
      rxd = v;
      repeat (n * bt) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] d, input int wl, input bit flip,
                       input bit stopv, input int gap, input bit push);
      logic [15:0] mask;
      logic [7:0]  m;
      logic        p;
      exp_t        e;
      mask = (16'h1 << wl) - 16'h1;
      m    = d & mask[7:0];
      p    = lc[4] ? ^m : ~^m;
      if (flip) p = ~p;
      if (push) begin
         e.d = m;
         e.p = lc[3] & flip;
         e.f = ~stopv;
         e.o = 1'b0;
         e.b = (m == 8'h00) && (!lc[3] || !p) && !stopv;
         q.push_back(e);
      end
      line_bits(1'b0, 1);
      for (int i = 0; i < wl; i++) line_bits(m[i], 1);
      if (lc[3]) line_bits(p, 1);
      line_bits(stopv, 1);
      if (gap > 0) line_bits(1'b1, gap);
   endtask

   // monitor: pops expected items and reads each character out
   initial begin
      forever begin
         @(negedge clk);
         if (auto_rd && data_ready) begin
            exp_t e;
            if (q.size() == 0) begin
               chk("R8", "unexpected character", 1, 0);
            end else begin
               e = q.pop_front();
               chk("R3", "rx_byte", rx_byte, e.d);
               chk("R4", "err_parity", err_parity, e.p);
               chk("R6", "err_frame", err_frame, e.f);
               chk("R7", "err_break", err_break, e.b);
               chk("R9", "err_overrun", err_overrun, e.o);
            end
            rd_data = 1'b1;
            rd_status = 1'b1;
            @(negedge clk);
            rd_data = 1'b0;
            rd_status = 1'b0;
            @(negedge clk);
            chk("R8", "data_ready after read", data_ready, 0);
            chk("R10", "flags after status read",
                {err_parity, err_frame, err_overrun, err_break}, 0);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      chk("R1", "watchdog expired", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      exp_t e;
      repeat (5) @(negedge clk);
      chk("R11", "reset data_ready", data_ready, 0);
      chk("R11", "reset rx_byte", rx_byte, 0);
      chk("R11", "reset flags", {err_parity, err_frame, err_overrun, err_break}, 0);
      rst_n = 1'b1;
      line_bits(1'b1, 2);

      // R3 8-bit, no parity
      lc = cfg(8, 0, 0, 0);
      send(8'hA5, 8, 0, 1, 1, 1);
      send(8'h3C, 8, 0, 1, 1, 1);
      send(8'h00, 8, 0, 1, 1, 1);
      send(8'hFF, 8, 0, 1, 1, 1);

      // R1 other divisor
      div = 16'd3; bt = 48;
      line_bits(1'b1, 1);
      send(8'h5A, 8, 0, 1, 1, 1);
      div = 16'd2; bt = 32;
      line_bits(1'b1, 1);

      // R3 shorter words
      lc = cfg(5, 0, 0, 0); send(8'hF5, 5, 0, 1, 1, 1);
      lc = cfg(6, 0, 0, 0); send(8'hEA, 6, 0, 1, 1, 1);
      lc = cfg(7, 0, 0, 0); send(8'h81, 7, 0, 1, 1, 1);

      // R4 parity
      lc = cfg(8, 1, 1, 0); send(8'h37, 8, 0, 1, 1, 1); send(8'h37, 8, 1, 1, 1, 1);
      lc = cfg(8, 1, 0, 0); send(8'hC8, 8, 0, 1, 1, 1); send(8'hC8, 8, 1, 1, 1, 1);
      lc = cfg(7, 1, 0, 0); send(8'h55, 7, 1, 1, 1, 1);
      lc = cfg(8, 0, 1, 0); send(8'h11, 8, 0, 1, 1, 1);

      // R5 two stops configured, frames sent back to back with one stop
      lc = cfg(8, 0, 0, 1);
      send(8'h12, 8, 0, 1, 0, 1);
      send(8'h34, 8, 0, 1, 0, 1);
      send(8'h56, 8, 0, 1, 1, 1);

      // R6 framing error then resync
      lc = cfg(8, 0, 0, 0);
      send(8'h6B, 8, 0, 0, 1, 1);
      send(8'h29, 8, 0, 1, 1, 1);

      // R7 break then resync
      e = '{d: 8'h00, p: 1'b0, f: 1'b1, o: 1'b0, b: 1'b1};
      q.push_back(e);
      line_bits(1'b0, 12);
      line_bits(1'b1, 2);
      send(8'hC3, 8, 0, 1, 1, 1);

      // R2 short glitch
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      line_bits(1'b1, 2);
      chk("R2", "no character after glitch", data_ready, 0);
      send(8'h4D, 8, 0, 1, 1, 1);

      // R1 divisor zero halts
      div = 16'd0;
      send(8'h77, 8, 0, 1, 2, 0);
      chk("R1", "no character at divisor 0", data_ready, 0);
      div = 16'd2;
      line_bits(1'b1, 2);
      send(8'h99, 8, 0, 1, 1, 1);

      // R9 overrun
      auto_rd = 1'b0;
      send(8'hAA, 8, 0, 1, 1, 0);
      send(8'hBB, 8, 0, 1, 2, 0);
      chk("R9", "data_ready held", data_ready, 1);
      chk("R9", "newer byte kept", rx_byte, 8'hBB);
      chk("R9", "err_overrun", err_overrun, 1);
      chk("R9", "no other flags", {err_parity, err_frame, err_break}, 0);
      e = '{d: 8'hBB, p: 1'b0, f: 1'b0, o: 1'b1, b: 1'b0};
      q.push_back(e);
      auto_rd = 1'b1;
      repeat (10) @(negedge clk);

      chk("R8", "all expected characters seen", q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule